// File: doc/BRIEF.md
# Float-to-Integer Conversion Unit

This unit turns one IEEE-754 operand into a signed integer. The operand may be single or double precision, and the target may be 32 or 64 bits wide. Five operations are available: truncate, floor, ceiling, nearest-even, and a mode-directed conversion that takes its direction from a two-bit rounding-mode input. A single-precision operand is read from the low 32 bits of the operand bus.

Every accepted conversion ORs its exception events (inexact, overflow, invalid) into a sticky three-bit flag register. Software clears or rewrites that register only through an explicit write. When a conversion is invalid, the result is replaced by a fixed sentinel. A request for a 64-bit target while the register file is in 32-bit mode is reported as unsupported and leaves the flags untouched.

The unit accepts one request per cycle. Results appear one clock after the request is accepted.

Top module: `fcvt_unit`

## Requirements
- R1: Operation code 0 truncates toward zero. Codes 5 to 7 behave the same way.
- R2: Operation code 1 rounds toward minus infinity (floor). Operation code 2 rounds toward plus infinity (ceiling).
- R3: Operation code 3 rounds to the nearest integer. An exact halfway value goes to the even neighbour.
- R4: Operation code 4 takes its direction from `rmode`: 0 nearest-even, 1 toward zero, 2 toward plus infinity, 3 toward minus infinity.
- R5: A NaN or infinite operand sets only the invalid flag (flag bit 2), and the result is marked invalid.
- R6: A finite operand whose value is not an integer sets the inexact flag (flag bit 0). An operand that is already integral sets no flag.
- R7: If the rounded value is at or above the largest target integer, or at or below the smallest, both overflow (bit 1) and invalid (bit 2) are set. Values strictly inside that range convert normally.
- R8: An invalid result is replaced by 0x7FFFFFFF for a 32-bit target and by 0x7FFFFFFFFFFFFFFF for a 64-bit target. Valid 32-bit results are sign-extended to 64 bits.
- R9: When `in_w64`=1 and `fp64_mode`=0, the unit asserts `out_unsupp` and returns result 0 with `out_invalid` low. The flags are left unchanged.
- R10: Flags are sticky and accumulate across conversions. A flag write replaces the register. If a write and a conversion fall in the same cycle, the new value is the written data ORed with the conversion's flags.
- R11: `out_valid` rises exactly one clock after an accepted request. After reset, `out_valid`, the result and the flags are all zero.
- R12: In single format, only the low 32 bits of `in_opnd` are used, and the upper bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Conversion request |
| in_opnd | input | 64 | Operand bits |
| in_dbl | input | 1 | 1 = double, 0 = single (low 32 bits) |
| in_w64 | input | 1 | 1 = 64-bit target, 0 = 32-bit target |
| in_op | input | 3 | Operation code (0 trunc, 1 floor, 2 ceil, 3 nearest, 4 by mode) |
| fp64_mode | input | 1 | Register file is in 64-bit mode |
| rmode | input | 2 | Rounding mode used by operation 4 |
| flag_we | input | 1 | Explicit flag write |
| flag_wdata | input | 3 | Flag write data {invalid, overflow, inexact} |
| out_valid | output | 1 | Result valid, one cycle after request |
| out_result | output | 64 | Integer result or sentinel |
| out_invalid | output | 1 | Result was invalid |
| out_unsupp | output | 1 | Request was unsupported |
| flags | output | 3 | Sticky flags {invalid, overflow, inexact} |

## Verification
An explicit flag write and a conversion's flag update can land on the same clock edge. This is the interaction that needs checking. Every table vector is issued together with a write of zero, so the flags seen afterwards must be exactly that conversion's own events and nothing left over from earlier vectors. A directed test then writes a non-zero pattern together with an inexact conversion, and expects the OR of the two. Further directed tests confirm that flags accumulate when no write is made, that a bare write replaces the register, and that an unsupported request leaves the register intact.

// File: rtl/fcvt_pkg.sv
package fcvt_pkg;
  localparam int SIG_W   = 53;
  localparam int EXP_W   = 13;
  localparam int INT_W   = 64;
  localparam int FRAC_W  = 66;
  localparam int WIDE_W  = INT_W + FRAC_W;
  localparam int SH_OFF  = FRAC_W - (SIG_W - 1);
  localparam int SH_W    = $clog2(INT_W + SH_OFF);
  localparam int FLAG_W  = 3;
  localparam int FLG_INEX = 0;
  localparam int FLG_OVF  = 1;
  localparam int FLG_INV  = 2;

  typedef enum logic [2:0] {
    OP_TRUNC = 3'd0, OP_FLOOR = 3'd1, OP_CEIL = 3'd2, OP_NEAR = 3'd3, OP_MODE = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    DIR_NEAR = 2'd0, DIR_ZERO = 2'd1, DIR_UP = 2'd2, DIR_DOWN = 2'd3
  } dir_e;

  typedef struct packed {
    logic                    sign;
    logic                    is_nan;
    logic                    is_inf;
    logic                    nz;
    logic signed [EXP_W-1:0] exp;
    logic [SIG_W-1:0]        sig;
  } unp_t;
endpackage

// File: rtl/fcvt_unpack.sv
module fcvt_unpack
  import fcvt_pkg::*;
#(
  parameter int D_EXP = 11,
  parameter int D_MAN = 52,
  parameter int S_EXP = 8,
  parameter int S_MAN = 23
) (
  input  logic [63:0] opnd,
  input  logic        is_dbl,
  output unp_t        unp
);
  localparam int D_BIAS = (1 << (D_EXP - 1)) - 1;
  localparam int S_BIAS = (1 << (S_EXP - 1)) - 1;
  localparam int S_PAD  = (SIG_W - 1) - S_MAN;

  logic [D_EXP-1:0] d_ef;
  logic [D_MAN-1:0] d_fr;
  logic [S_EXP-1:0] s_ef;
  logic [S_MAN-1:0] s_fr;
  unp_t d_u, s_u;

  always_comb begin
    d_ef = opnd[D_MAN +: D_EXP];
    d_fr = opnd[D_MAN-1:0];
    d_u.sign   = opnd[D_MAN + D_EXP];
    d_u.is_inf = (&d_ef) && (d_fr == '0);
    d_u.is_nan = (&d_ef) && (d_fr != '0);
    d_u.nz     = (d_ef != '0) || (d_fr != '0);
    d_u.exp    = (d_ef == '0) ? EXP_W'(1 - D_BIAS)
                              : EXP_W'(int'(d_ef) - D_BIAS);
    d_u.sig    = {(d_ef != '0), d_fr};

    s_ef = opnd[S_MAN +: S_EXP];
    s_fr = opnd[S_MAN-1:0];
    s_u.sign   = opnd[S_MAN + S_EXP];
    s_u.is_inf = (&s_ef) && (s_fr == '0);
    s_u.is_nan = (&s_ef) && (s_fr != '0);
    s_u.nz     = (s_ef != '0) || (s_fr != '0);
    s_u.exp    = (s_ef == '0) ? EXP_W'(1 - S_BIAS)
                              : EXP_W'(int'(s_ef) - S_BIAS);
    s_u.sig    = {(s_ef != '0), s_fr, {S_PAD{1'b0}}};

    unp = is_dbl ? d_u : s_u;
  end
endmodule

// File: rtl/fcvt_round.sv
module fcvt_round
  import fcvt_pkg::*;
(
  input  unp_t        unp,
  input  dir_e        dir,
  input  logic        w64,
  output logic [63:0] result,
  output logic [FLAG_W-1:0] evt,
  output logic        invalid
);
  localparam logic [INT_W:0] LIM_P64 = {2'b00, {(INT_W-1){1'b1}}};
  localparam logic [INT_W:0] LIM_N64 = {2'b01, {(INT_W-1){1'b0}}};
  localparam logic [INT_W:0] LIM_P32 = (INT_W+1)'(32'h7FFF_FFFF);
  localparam logic [INT_W:0] LIM_N32 = (INT_W+1)'(32'h8000_0000);

  logic                    finite, big, tiny, g, s, lsb, inc, ovf;
  logic signed [EXP_W-1:0] sh_full;
  logic [SH_W-1:0]         sh;
  logic [WIDE_W-1:0]       wide;
  logic [INT_W-1:0]        ipart, sval;
  logic [INT_W:0]          mag, lim_p, lim_n;

  always_comb begin
    finite  = !unp.is_nan && !unp.is_inf;
    big     = unp.exp > EXP_W'(INT_W - 1);
    tiny    = unp.exp < -EXP_W'(SH_OFF);
    sh_full = unp.exp + EXP_W'(SH_OFF);
    sh      = (big || tiny) ? '0 : sh_full[SH_W-1:0];
    wide    = {{(WIDE_W-SIG_W){1'b0}}, unp.sig} << sh;
    if (tiny) begin
      ipart = '0; g = 1'b0; s = unp.nz;
    end else if (big) begin
      ipart = '0; g = 1'b0; s = 1'b0;
    end else begin
      ipart = wide[WIDE_W-1:FRAC_W];
      g     = wide[FRAC_W-1];
      s     = |wide[FRAC_W-2:0];
    end
    lsb = ipart[0];
    unique case (dir)
      DIR_NEAR: inc = g && (s || lsb);
      DIR_ZERO: inc = 1'b0;
      DIR_UP:   inc = !unp.sign && (g || s);
      default:  inc = unp.sign && (g || s);
    endcase
    mag   = {1'b0, ipart} + (INT_W+1)'(inc);
    lim_p = w64 ? LIM_P64 : LIM_P32;
    lim_n = w64 ? LIM_N64 : LIM_N32;
    ovf   = finite && (big || (unp.sign ? (mag >= lim_n) : (mag >= lim_p)));
    invalid = !finite || ovf;
    evt[FLG_INEX] = finite && !big && (g || s);
    evt[FLG_OVF]  = ovf;
    evt[FLG_INV]  = invalid;
    sval = unp.sign ? (~mag[INT_W-1:0] + 1'b1) : mag[INT_W-1:0];
    if (invalid)
      result = w64 ? 64'h7FFF_FFFF_FFFF_FFFF : 64'h0000_0000_7FFF_FFFF;
    else
      result = w64 ? sval : {{32{sval[31]}}, sval[31:0]};
  end
endmodule

// File: rtl/fcvt_flags.sv
module fcvt_flags
  import fcvt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [FLAG_W-1:0] wdata,
  input  logic              upd,
  input  logic [FLAG_W-1:0] evt,
  output logic [FLAG_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= (we ? wdata : q) | (upd ? evt : '0);
  end

  assert_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    !$past(we) |-> ((q & $past(q)) == $past(q)));
endmodule

// File: rtl/fcvt_unit.sv
module fcvt_unit
  import fcvt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [63:0]       in_opnd,
  input  logic              in_dbl,
  input  logic              in_w64,
  input  logic [2:0]        in_op,
  input  logic              fp64_mode,
  input  logic [1:0]        rmode,
  input  logic              flag_we,
  input  logic [2:0]        flag_wdata,
  output logic              out_valid,
  output logic [63:0]       out_result,
  output logic              out_invalid,
  output logic              out_unsupp,
  output logic [2:0]        flags
);
  unp_t              unp;
  dir_e              dir;
  logic [63:0]       cv_res;
  logic [FLAG_W-1:0] cv_evt;
  logic              cv_inv, unsupp;

  always_comb begin
    unique case (in_op)
      OP_FLOOR: dir = DIR_DOWN;
      OP_CEIL:  dir = DIR_UP;
      OP_NEAR:  dir = DIR_NEAR;
      OP_MODE:  dir = dir_e'(rmode);
      default:  dir = DIR_ZERO;
    endcase
    unsupp = in_w64 && !fp64_mode;
  end

  fcvt_unpack u_unpack (.opnd(in_opnd), .is_dbl(in_dbl), .unp(unp));

  fcvt_round u_round (
    .unp(unp), .dir(dir), .w64(in_w64),
    .result(cv_res), .evt(cv_evt), .invalid(cv_inv)
  );

  fcvt_flags u_flags (
    .clk(clk), .rst(rst), .we(flag_we), .wdata(flag_wdata),
    .upd(in_valid && !unsupp), .evt(cv_evt), .q(flags)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_invalid <= 1'b0;
      out_unsupp  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result  <= unsupp ? 64'd0 : cv_res;
        out_invalid <= !unsupp && cv_inv;
        out_unsupp  <= unsupp;
      end
    end
  end

  assert_latency_R11: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_sentinel_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_invalid) |->
      (out_result == 64'h7FFF_FFFF_FFFF_FFFF || out_result == 64'h0000_0000_7FFF_FFFF));
  assert_invflag_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_invalid) |-> flags[FLG_INV]);
  assert_unsupp_keep_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_unsupp && !$past(flag_we)) |-> (flags == $past(flags)));
  assert_unsupp_res_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_unsupp) |-> (out_result == 64'd0 && !out_invalid));
endmodule

// File: tb/test_fcvt_unit.sv
module test_fcvt_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] in_opnd = '0;
  logic        in_dbl = 1'b1, in_w64 = 1'b0, fp64_mode = 1'b1;
  logic [2:0]  in_op = '0;
  logic [1:0]  rmode = '0;
  logic        flag_we = 1'b0;
  logic [2:0]  flag_wdata = '0;
  logic        out_valid, out_invalid, out_unsupp;
  logic [63:0] out_result;
  logic [2:0]  flags;
  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  fcvt_unit i_fcvt_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_opnd(in_opnd),
    .in_dbl(in_dbl), .in_w64(in_w64), .in_op(in_op), .fp64_mode(fp64_mode),
    .rmode(rmode), .flag_we(flag_we), .flag_wdata(flag_wdata),
    .out_valid(out_valid), .out_result(out_result), .out_invalid(out_invalid),
    .out_unsupp(out_unsupp), .flags(flags)
  );

  localparam logic [63:0] S32 = 64'h0000_0000_7FFF_FFFF;
  localparam logic [63:0] S64 = 64'h7FFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] P27 = 64'h4005_9999_9999_999A;
  localparam logic [63:0] N27 = 64'hC005_9999_9999_999A;
  localparam int NV = 36;
  // {req, fp64, dbl, w64, op, rm, operand, result, flags{inv,ovf,inex}, invalid}
  localparam logic [143:0] VEC [NV] = '{
    {4'd1, 3'b110, 3'd0, 2'd0, P27, 64'd2, 3'b001, 1'b0},                       // R1
    {4'd1, 3'b110, 3'd0, 2'd0, N27, 64'hFFFF_FFFF_FFFF_FFFE, 3'b001, 1'b0},     // R1
    {4'd1, 3'b110, 3'd6, 2'd0, N27, 64'hFFFF_FFFF_FFFF_FFFE, 3'b001, 1'b0},     // R1 code 6
    {4'd2, 3'b110, 3'd1, 2'd0, N27, 64'hFFFF_FFFF_FFFF_FFFD, 3'b001, 1'b0},     // R2
    {4'd2, 3'b110, 3'd1, 2'd0, P27, 64'd2, 3'b001, 1'b0},                       // R2
    {4'd2, 3'b110, 3'd2, 2'd0, P27, 64'd3, 3'b001, 1'b0},                       // R2
    {4'd2, 3'b110, 3'd2, 2'd0, N27, 64'hFFFF_FFFF_FFFF_FFFE, 3'b001, 1'b0},     // R2
    {4'd3, 3'b110, 3'd3, 2'd0, 64'h4004_0000_0000_0000, 64'd2, 3'b001, 1'b0},   // R3 2.5
    {4'd3, 3'b110, 3'd3, 2'd0, 64'h400C_0000_0000_0000, 64'd4, 3'b001, 1'b0},   // R3 3.5
    {4'd3, 3'b110, 3'd3, 2'd0, 64'hC004_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFE, 3'b001, 1'b0}, // R3
    {4'd3, 3'b110, 3'd3, 2'd0, 64'h3FE0_0000_0000_0000, 64'd0, 3'b001, 1'b0},   // R3 0.5
    {4'd3, 3'b110, 3'd3, 2'd0, 64'h3FF8_0000_0000_0000, 64'd2, 3'b001, 1'b0},   // R3 1.5
    {4'd3, 3'b110, 3'd3, 2'd0, P27, 64'd3, 3'b001, 1'b0},                       // R3
    {4'd4, 3'b110, 3'd4, 2'd0, 64'h4004_0000_0000_0000, 64'd2, 3'b001, 1'b0},   // R4
    {4'd4, 3'b110, 3'd4, 2'd1, N27, 64'hFFFF_FFFF_FFFF_FFFE, 3'b001, 1'b0},     // R4
    {4'd4, 3'b110, 3'd4, 2'd2, N27, 64'hFFFF_FFFF_FFFF_FFFE, 3'b001, 1'b0},     // R4
    {4'd4, 3'b110, 3'd4, 2'd2, P27, 64'd3, 3'b001, 1'b0},                       // R4
    {4'd4, 3'b110, 3'd4, 2'd3, P27, 64'd2, 3'b001, 1'b0},                       // R4
    {4'd4, 3'b110, 3'd4, 2'd3, N27, 64'hFFFF_FFFF_FFFF_FFFD, 3'b001, 1'b0},     // R4
    {4'd5, 3'b110, 3'd0, 2'd0, 64'h7FF0_0000_0000_0000, S32, 3'b100, 1'b1},     // R5
    {4'd5, 3'b111, 3'd0, 2'd0, 64'h7FF8_0000_0000_0000, S64, 3'b100, 1'b1},     // R5
    {4'd5, 3'b100, 3'd3, 2'd0, 64'h0000_0000_7F80_0000, S32, 3'b100, 1'b1},     // R5
    {4'd6, 3'b110, 3'd0, 2'd0, 64'h4000_0000_0000_0000, 64'd2, 3'b000, 1'b0},   // R6
    {4'd6, 3'b110, 3'd0, 2'd0, 64'h0000_0000_0000_0000, 64'd0, 3'b000, 1'b0},   // R6
    {4'd7, 3'b110, 3'd0, 2'd0, 64'h41DF_FFFF_FFC0_0000, S32, 3'b110, 1'b1},     // R7
    {4'd7, 3'b110, 3'd0, 2'd0, 64'hC1E0_0000_0000_0000, S32, 3'b110, 1'b1},     // R7
    {4'd7, 3'b110, 3'd2, 2'd0, 64'h41DF_FFFF_FFA0_0000, S32, 3'b111, 1'b1},     // R7
    {4'd7, 3'b110, 3'd0, 2'd0, 64'h41DF_FFFF_FF80_0000, 64'h7FFF_FFFE, 3'b000, 1'b0}, // R7
    {4'd7, 3'b110, 3'd0, 2'd0, 64'hC1DF_FFFF_FFC0_0000, 64'hFFFF_FFFF_8000_0001, 3'b000, 1'b0}, // R7
    {4'd8, 3'b111, 3'd0, 2'd0, 64'h41DF_FFFF_FFC0_0000, 64'h7FFF_FFFF, 3'b000, 1'b0}, // R8
    {4'd8, 3'b111, 3'd0, 2'd0, 64'h43E0_0000_0000_0000, S64, 3'b110, 1'b1},     // R8
    {4'd8, 3'b111, 3'd0, 2'd0, 64'hC3E0_0000_0000_0000, S64, 3'b110, 1'b1},     // R8
    {4'd8, 3'b111, 3'd0, 2'd0, 64'h43D0_0000_0000_0000, 64'h4000_0000_0000_0000, 3'b000, 1'b0}, // R8
    {4'd12, 3'b100, 3'd0, 2'd0, 64'hDEAD_BEEF_42C9_8000, 64'd100, 3'b001, 1'b0}, // R12
    {4'd12, 3'b100, 3'd3, 2'd0, 64'hDEAD_BEEF_4020_0000, 64'd2, 3'b001, 1'b0},   // R12
    {4'd12, 3'b100, 3'd2, 2'd0, 64'hFFFF_FFFF_BF00_0000, 64'd0, 3'b001, 1'b0}    // R12
  };

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic issue(input logic f64, input logic dbl, input logic w64,
                       input logic [2:0] op, input logic [1:0] rm,
                       input logic [63:0] v, input logic we, input logic [2:0] wd);
    @(negedge clk);
    fp64_mode = f64; in_dbl = dbl; in_w64 = w64; in_op = op; rmode = rm;
    in_opnd = v; in_valid = 1'b1; flag_we = we; flag_wdata = wd;
    @(negedge clk);
    in_valid = 1'b0; flag_we = 1'b0;
  endtask

  task automatic write_flags(input logic [2:0] wd);
    @(negedge clk);
    flag_we = 1'b1; flag_wdata = wd;
    @(negedge clk);
    flag_we = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL R11 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R11: reset state
    chk("R11 reset out_valid", 64'(out_valid), 64'd0);
    chk("R11 reset result", out_result, 64'd0);
    chk("R11 reset flags", 64'(flags), 64'd0);

    // Table: each vector issued with a flag write of zero in the same cycle
    for (int i = 0; i < NV; i++) begin
      automatic logic [143:0] v = VEC[i];
      issue(v[139], v[138], v[137], v[136:134], v[133:132], v[131:68], 1'b1, 3'b000);
      chk($sformatf("R%0d vec%0d result", v[143:140], i), out_result, v[67:4]);
      chk($sformatf("R%0d vec%0d flags", v[143:140], i), 64'(flags), 64'(v[3:1]));
      chk($sformatf("R%0d vec%0d invalid", v[143:140], i), 64'(out_invalid), 64'(v[0]));
      chk($sformatf("R%0d vec%0d valid", v[143:140], i), 64'(out_valid), 64'd1);
    end

    // R11: out_valid is a one-cycle pulse
    @(negedge clk);
    chk("R11 out_valid drops", 64'(out_valid), 64'd0);

    // R10: accumulation without writes
    write_flags(3'b000);
    chk("R10 write clears", 64'(flags), 64'd0);
    issue(1'b1, 1'b1, 1'b0, 3'd0, 2'd0, P27, 1'b0, 3'b000);
    chk("R10 first event", 64'(flags), 64'b001);
    issue(1'b1, 1'b1, 1'b0, 3'd0, 2'd0, 64'h7FF0_0000_0000_0000, 1'b0, 3'b000);
    chk("R10 accumulate", 64'(flags), 64'b101);
    issue(1'b1, 1'b1, 1'b0, 3'd0, 2'd0, 64'h4000_0000_0000_0000, 1'b0, 3'b000);
    chk("R10 exact keeps", 64'(flags), 64'b101);
    write_flags(3'b010);
    chk("R10 write replaces", 64'(flags), 64'b010);
    issue(1'b1, 1'b1, 1'b0, 3'd0, 2'd0, P27, 1'b1, 3'b100);
    chk("R10 same-cycle write OR event", 64'(flags), 64'b101);

    // R9: unsupported 64-bit target in 32-bit register mode
    write_flags(3'b001);
    issue(1'b0, 1'b1, 1'b1, 3'd0, 2'd0, 64'h7FF8_0000_0000_0000, 1'b0, 3'b000);
    chk("R9 unsupp flag", 64'(out_unsupp), 64'd1);
    chk("R9 unsupp result", out_result, 64'd0);
    chk("R9 unsupp invalid", 64'(out_invalid), 64'd0);
    chk("R9 flags kept", 64'(flags), 64'b001);
    issue(1'b0, 1'b1, 1'b0, 3'd0, 2'd0, P27, 1'b0, 3'b000);
    chk("R9 32-bit target still allowed", out_result, 64'd2);
    chk("R9 unsupp clears", 64'(out_unsupp), 64'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule